// File: doc/BRIEF.md
# Pulse Interval Capture Timer

This block is one timer channel that measures the spacing between successive qualifying transitions on an external input pin. A 16-bit up-counter advances on each enabled tick of a count source. The count source is one of several prescaled clock-enable strobes, chosen by a select input. When the conditioned input shows a qualifying transition, three things happen at one clock edge. The running count is latched into a capture register, the counter restarts from zero, and a one-cycle interrupt pulse is raised. At the same edge a flag records whether the counter wrapped past its maximum since the previous capture. Software can therefore rebuild intervals longer than 16 bits: interval = tick period × (65536 × flag + captured value + 1). The flag is only meaningful when at most one wrap occurred in the period.

The pin is brought into the clock domain through a two-flop synchronizer, so an edge is seen up to one clock late. An optional glitch filter passes a new level only after three equal consecutive samples. An edge-mode input picks falling, rising, both or no transitions. The channel is started and stopped by single-cycle strobes. A start strobe while running forces a capture, just as a pin edge would. A trigger-mode input can make the first qualifying pin edge, rather than the start strobe, begin the count.

Top module: `pulse_interval_timer`

## Requirements
- R1: After reset, `cap_val` is 0, `ovf_flag` is 0, `irq` is 0 and `running` is 0.
- R2: With `trig_sel` other than 3'b001, a `sw_start` pulse while stopped clears the counter and sets `running` at the next edge. From then on the counter adds one on each clock where bit `clk_sel` of `tick_src` is high.
- R3: A qualifying edge while running loads the count into `cap_val`, clears the counter, and raises `irq` for one cycle, all at one clock edge. The captured value equals the number of ticks counted since the previous capture or start.
- R4: At each capture, `ovf_flag` becomes 1 if the counter wrapped from 0xFFFF to 0 since the previous capture or start, and 0 otherwise. A capture taken 65536 ticks after the last one gives value 0 with the flag at 1. A capture taken 65535 ticks after gives value 0xFFFF with the flag at 0.
- R5: A `sw_start` pulse while running performs a capture exactly like a qualifying pin edge, and `irq` follows at the next edge.
- R6: `edge_sel` picks the qualifying transition: 2'b00 falling, 2'b01 rising, 2'b10 both, 2'b11 none. Non-qualifying transitions cause no interrupt and leave `cap_val` unchanged.
- R7: With the filter off, a change on `cap_in` set up before clock edge k produces `irq` high right after edge k+2, and low before that.
- R8: With `filt_en` set, a new level is accepted only after three equal consecutive synchronized samples. A pulse two clocks wide causes no interrupt. A pulse three clocks wide yields its edges, each with `irq` right after edge k+5.
- R9: With `trig_sel` = 3'b001, `sw_start` only arms the channel (`running` stays 0). The first qualifying edge starts counting from zero and sets `running`, with no capture and no interrupt. Later edges capture normally.
- R10: A `sw_stop` pulse clears `running` and freezes the counter. While stopped, pin edges are ignored. A `sw_start` in the same cycle as `sw_stop` is ignored.
- R11: `cap_val` and `ovf_flag` change only at a capture, so they hold their values across stops until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_src | input | 4 | Prescaled clock-enable strobes, one per source |
| clk_sel | input | 2 | Index of the strobe used as count tick |
| trig_sel | input | 3 | 3'b001: pin edge starts counting; other values: start strobe starts counting |
| edge_sel | input | 2 | Qualifying transition: 00 falling, 01 rising, 10 both, 11 none |
| filt_en | input | 1 | Enables the three-sample glitch filter |
| cap_in | input | 1 | Asynchronous measured input pin |
| sw_start | input | 1 | Start strobe; forces a capture when running |
| sw_stop | input | 1 | Stop strobe |
| cap_val | output | 16 | Last captured count |
| ovf_flag | output | 1 | Wrap status of the last captured period |
| irq | output | 1 | One-cycle capture interrupt |
| running | output | 1 | Counter is active |

## Verification
Short, exactly known intervals, each closed by a software capture, pin the captured value to a tick count. The same is done on a gated tick source, which separates counting ticks from counting clocks. Two captures straddle the 16-bit boundary, 65535 and 65536 ticks apart, and a short one follows. Together they tell a wrap that is latched correctly from an off-by-one and from a flag that sticks. Directed pin toggles under each edge mode, with the filter on and off, fix the interrupt cycle exactly. Two-clock and three-clock pulses separate filtered from unfiltered behaviour. A seeded random run then mixes tick patterns, source selects, edge modes, filter settings and overlapping software captures against a bench model of tick counting.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_RUN   = 2'b10
  } run_state_e;

  localparam logic [2:0] TRIG_EDGE_START = 3'b001;

endpackage

// File: rtl/pit_rst_sync.sv
module pit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pit_tick_sel.sv
module pit_tick_sel #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) tick = src_en[i];
    end
  end

endmodule

// File: rtl/pit_in_cond.sv
module pit_in_cond
  import pit_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  localparam int HIST_W     = FILT_LEN - 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       filt_en,
  input  edge_mode_e edge_mode,
  output logic       edge_hit
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [HIST_W-1:0]      hist_q, hist_d;
  logic                   filt_q, filt_d;
  logic                   lvl_q, lvl_d;
  logic                   sync_lvl;
  logic                   all_same;
  logic                   rise, fall;

  assign sync_lvl = sync_q[SYNC_STAGES-1];
  assign all_same = (&{hist_q, sync_lvl}) | ~(|{hist_q, sync_lvl});

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    hist_d = HIST_W'({hist_q, sync_lvl});
    filt_d = all_same ? sync_lvl : filt_q;
    lvl_d  = filt_en ? filt_q : sync_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      filt_q <= filt_d;
      lvl_q  <= lvl_d;
    end
  end

  assign rise = lvl_d & ~lvl_q;
  assign fall = ~lvl_d & lvl_q;

  always_comb begin
    unique case (edge_mode)
      EDGE_FALL: edge_hit = fall;
      EDGE_RISE: edge_hit = rise;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             edge_hit,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic [2:0]       trig_sel,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap,
  output logic             ovf,
  output logic             irq,
  output logic             running
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  run_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             wrap_q, wrap_d;
  logic             ovf_q, ovf_d;
  logic             irq_q, irq_d;
  logic             do_capture;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    wrap_d     = wrap_q;
    do_capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sw_start && !sw_stop) begin
          cnt_d   = '0;
          wrap_d  = 1'b0;
          state_d = (trig_sel == TRIG_EDGE_START) ? ST_ARMED : ST_RUN;
        end
      end
      ST_ARMED: begin
        if (sw_stop) begin
          state_d = ST_IDLE;
        end else if (edge_hit) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          wrap_d  = 1'b0;
        end
      end
      ST_RUN: begin
        if (sw_stop) begin
          state_d = ST_IDLE;
        end else if (edge_hit || sw_start) begin
          do_capture = 1'b1;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_MAX) wrap_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    cap_d = cap_q;
    ovf_d = ovf_q;
    irq_d = 1'b0;
    if (do_capture) begin
      cap_d  = cnt_q;
      ovf_d  = wrap_q;
      cnt_d  = '0;
      wrap_d = 1'b0;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wrap_q  <= 1'b0;
      cap_q   <= '0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wrap_q  <= wrap_d;
      cap_q   <= cap_d;
      ovf_q   <= ovf_d;
      irq_q   <= irq_d;
    end
  end

  assign count   = cnt_q;
  assign cap     = cap_q;
  assign ovf     = ovf_q;
  assign irq     = irq_q;
  assign running = (state_q == ST_RUN);

endmodule

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer
  import pit_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int RST_STAGES  = 2,
  localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tick_src,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic [2:0]         trig_sel,
  input  logic [1:0]         edge_sel,
  input  logic               filt_en,
  input  logic               cap_in,
  input  logic               sw_start,
  input  logic               sw_stop,
  output logic [CNT_W-1:0]   cap_val,
  output logic               ovf_flag,
  output logic               irq,
  output logic               running
);

  logic             rst_ns;
  logic             tick_w;
  logic             edge_w;
  logic [CNT_W-1:0] count_w;

  pit_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_ns)
  );

  pit_tick_sel #(.NUM_SRC(NUM_SRC)) u_tick (
    .src_en (tick_src),
    .sel    (clk_sel),
    .tick   (tick_w)
  );

  pit_in_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_in (
    .clk       (clk),
    .rst_n     (rst_ns),
    .pin       (cap_in),
    .filt_en   (filt_en),
    .edge_mode (edge_mode_e'(edge_sel)),
    .edge_hit  (edge_w)
  );

  pit_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_ns),
    .tick     (tick_w),
    .edge_hit (edge_w),
    .sw_start (sw_start),
    .sw_stop  (sw_stop),
    .trig_sel (trig_sel),
    .count    (count_w),
    .cap      (cap_val),
    .ovf      (ovf_flag),
    .irq      (irq),
    .running  (running)
  );

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             running,
  input logic             sw_start,
  input logic             ovf_flag,
  input logic [CNT_W-1:0] cap_val,
  input logic [CNT_W-1:0] count
);

  // R3: the counter restarts from zero at every capture
  a_r3_clear_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0));

  // R3: the captured value is the count held just before the capture edge
  a_r3_capture_takes_count: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_val == $past(count)));

  // R10: no capture can come from a stopped or armed channel
  a_r10_capture_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(running));

  // R10: a stopped channel keeps its count unless a start arrives
  a_r10_halt_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !sw_start) |=> $stable(count));

  // R11: capture register holds between captures
  a_r11_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(cap_val));

  // R11: overflow status holds between captures
  a_r11_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(ovf_flag));

endmodule

bind pulse_interval_timer pit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .running  (running),
  .sw_start (sw_start),
  .ovf_flag (ovf_flag),
  .cap_val  (cap_val),
  .count    (count_w)
);

// File: tb/pulse_interval_timer_tb.sv
`timescale 1ns/1ps
module pulse_interval_timer_tb;

  localparam int CW = 16;
  localparam int NS = 4;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] tick_src;
  logic [1:0]    clk_sel;
  logic [2:0]    trig_sel;
  logic [1:0]    edge_sel;
  logic          filt_en;
  logic          cap_in;
  logic          sw_start;
  logic          sw_stop;
  logic [CW-1:0] cap_val;
  logic          ovf_flag;
  logic          irq;
  logic          running;

  int          n_chk = 0;
  int          n_fail = 0;
  int          irq_seen = 0;
  logic [7:0]  exp_q;
  bit          exp_active;
  int unsigned mcnt;
  bit          mwrap;
  logic        ap_tick;
  logic        ap_run;

  pulse_interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .clk_sel(clk_sel),
    .trig_sel(trig_sel), .edge_sel(edge_sel), .filt_en(filt_en),
    .cap_in(cap_in), .sw_start(sw_start), .sw_stop(sw_stop),
    .cap_val(cap_val), .ovf_flag(ovf_flag), .irq(irq), .running(running)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int lat_idx(input logic f);
    return f ? 5 : 2;
  endfunction

  // one clock: record applied inputs, wait to the falling edge, compare
  task automatic step();
    ap_tick = tick_src[clk_sel];
    ap_run  = running;
    @(negedge clk);
    if (irq) irq_seen++;
    if (exp_q[0] || irq)
      chk(irq === exp_q[0], "R7", "irq timing", irq, exp_q[0]);
    if (irq) begin
      chk(cap_val == mcnt[CW-1:0], "R3", "captured ticks", cap_val, mcnt);
      chk(ovf_flag == mwrap, "R4", "wrap flag", ovf_flag, mwrap);
      mcnt = 0; mwrap = 0;
    end else if (running && !ap_run) begin
      mcnt = 0; mwrap = 0;
    end else if (running && ap_run && ap_tick) begin
      if (mcnt == 65535) begin mcnt = 0; mwrap = 1; end
      else mcnt++;
    end
    exp_q = exp_q >> 1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_in(input logic v);
    logic q;
    q = 1'b0;
    if (v !== cap_in) begin
      case (edge_sel)
        2'b00:   q = !v;
        2'b01:   q = v;
        2'b10:   q = 1'b1;
        default: q = 1'b0;
      endcase
    end
    if (q && exp_active) exp_q[lat_idx(filt_en)] = 1'b1;
    cap_in = v;
  endtask

  task automatic soft_start();
    sw_start = 1'b1;
    if (exp_active && running) exp_q[0] = 1'b1;
    step();
    sw_start = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int base;
    logic [CW-1:0] held_cap;
    logic          held_ovf;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick_src = '1; clk_sel = 2'd0; trig_sel = 3'b000;
    edge_sel = 2'b01; filt_en = 1'b0; cap_in = 1'b0; sw_start = 1'b0;
    sw_stop = 1'b0; exp_q = '0; exp_active = 1'b0; mcnt = 0; mwrap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(4);

    // R1 reset state
    chk(cap_val == 0, "R1", "cap_val", cap_val, 0);
    chk(ovf_flag == 0, "R1", "ovf_flag", ovf_flag, 0);
    chk(irq == 0, "R1", "irq", irq, 0);
    chk(running == 0, "R1", "running", running, 0);

    exp_active = 1'b1;
    // R2 start
    sw_start = 1'b1; step(); sw_start = 1'b0;
    chk(running == 1, "R2", "running after start", running, 1);
    run(9);
    // R5 software capture: 9 ticks
    soft_start();
    chk(irq == 1, "R5", "soft capture irq", irq, 1);
    chk(cap_val == 9, "R5", "soft capture value", cap_val, 9);

    // R2 gated tick source: 10 ticks in 30 clocks
    clk_sel = 2'd2;
    for (int i = 0; i < 30; i++) begin
      tick_src = {1'b1, (i % 3 == 0), 2'b11};
      step();
    end
    tick_src = '1;
    soft_start();
    chk(cap_val == 10, "R2", "gated tick count", cap_val, 10);
    clk_sel = 2'd0;

    // R3 edge capture, rising edges 24 clocks apart
    set_in(1'b1); run(12); set_in(1'b0); run(12); set_in(1'b1); run(12);
    chk(cap_val == 23, "R3", "edge interval", cap_val, 23);

    // R6 falling mode
    edge_sel = 2'b00;
    base = irq_seen;
    set_in(1'b0); run(8); set_in(1'b1); run(8);
    chk(irq_seen - base == 1, "R6", "falling mode irq count", irq_seen - base, 1);
    // R6 none mode
    edge_sel = 2'b11; held_cap = cap_val; base = irq_seen;
    set_in(1'b0); run(8); set_in(1'b1); run(8);
    chk(irq_seen - base == 0, "R6", "none mode irq count", irq_seen - base, 0);
    chk(cap_val == held_cap, "R6", "none mode cap hold", cap_val, held_cap);
    // R6 both mode
    edge_sel = 2'b10; base = irq_seen;
    set_in(1'b0); run(8); set_in(1'b1); run(8);
    chk(irq_seen - base == 2, "R6", "both mode irq count", irq_seen - base, 2);

    // R7 exact latency without filter
    set_in(1'b0); step(); step();
    chk(irq == 0, "R7", "irq before third edge", irq, 0);
    step();
    chk(irq == 1, "R7", "irq at third edge", irq, 1);
    run(8);

    // R8 filter: two-clock glitch rejected, three-clock pulse passes
    filt_en = 1'b1; run(8);
    exp_active = 1'b0; base = irq_seen;
    cap_in = 1'b1; run(2); cap_in = 1'b0; run(12);
    chk(irq_seen - base == 0, "R8", "two-clock glitch", irq_seen - base, 0);
    exp_active = 1'b1; base = irq_seen;
    set_in(1'b1); run(3); set_in(1'b0); run(12);
    chk(irq_seen - base == 2, "R8", "three-clock pulse", irq_seen - base, 2);
    set_in(1'b1); run(5);
    chk(irq == 0, "R8", "irq before sixth edge", irq, 0);
    step();
    chk(irq == 1, "R8", "irq at sixth edge", irq, 1);
    run(8);
    filt_en = 1'b0; run(8);

    // R4 wrap boundary
    soft_start();
    run(65535);
    soft_start();
    chk(cap_val == 16'hFFFF, "R4", "65535 ticks value", cap_val, 65535);
    chk(ovf_flag == 0, "R4", "65535 ticks flag", ovf_flag, 0);
    run(65536);
    soft_start();
    chk(cap_val == 0, "R4", "65536 ticks value", cap_val, 0);
    chk(ovf_flag == 1, "R4", "65536 ticks flag", ovf_flag, 1);
    run(5);
    soft_start();
    chk(cap_val == 5, "R4", "flag clears value", cap_val, 5);
    chk(ovf_flag == 0, "R4", "flag clears", ovf_flag, 0);

    // R10 stop
    held_cap = cap_val; held_ovf = ovf_flag;
    sw_stop = 1'b1; step(); sw_stop = 1'b0;
    chk(running == 0, "R10", "running after stop", running, 0);
    exp_active = 1'b0; base = irq_seen;
    edge_sel = 2'b10;
    set_in(1'b0); run(6); set_in(1'b1); run(6);
    sw_start = 1'b1; sw_stop = 1'b1; step(); sw_start = 1'b0; sw_stop = 1'b0;
    run(3);
    chk(running == 0, "R10", "start with stop ignored", running, 0);
    chk(irq_seen - base == 0, "R10", "edges ignored", irq_seen - base, 0);
    chk(cap_val == held_cap, "R11", "cap held over stop", cap_val, held_cap);
    chk(ovf_flag == held_ovf, "R11", "flag held over stop", ovf_flag, held_ovf);

    // R9 edge-started mode
    trig_sel = 3'b001; edge_sel = 2'b01;
    sw_start = 1'b1; step(); sw_start = 1'b0;
    run(5);
    chk(running == 0, "R9", "armed not running", running, 0);
    set_in(1'b0); run(6);
    base = irq_seen;
    set_in(1'b1); step(); step();
    chk(running == 0, "R9", "running before edge seen", running, 0);
    step();
    chk(running == 1, "R9", "running after first edge", running, 1);
    chk(irq_seen - base == 0, "R9", "no irq on start edge", irq_seen - base, 0);
    exp_active = 1'b1;
    run(7); set_in(1'b0); run(10); set_in(1'b1); run(8);
    chk(cap_val == 19, "R9", "first interval", cap_val, 19);
    trig_sel = 3'b000;

    // random mix
    for (int s = 0; s < 300; s++) begin
      int len;
      int ss;
      clk_sel  = 2'($urandom_range(0, 3));
      edge_sel = 2'($urandom_range(0, 3));
      filt_en  = 1'($urandom_range(0, 1));
      len = $urandom_range(12, 40);
      ss  = ($urandom_range(0, 3) == 0) ? $urandom_range(3, len - 1) : -1;
      for (int c = 0; c < len; c++) begin
        tick_src = 4'($urandom);
        if (c == 1 && $urandom_range(0, 4) != 0) set_in(!cap_in);
        if (c == ss) begin
          sw_start = 1'b1;
          if (running) exp_q[0] = 1'b1;
        end
        step();
        sw_start = 1'b0;
      end
    end
    run(10);

    summary();
    $finish;
  end

endmodule